// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block sequences the bus cycles of one DMA channel. Once a start address, a second address for memory-to-memory moves, a transfer count and a transfer kind are loaded while the machine is idle, an unmasked request makes it raise a hold request to the processor. When the processor grants the bus, the block runs one transfer after another. For each transfer it drives an address, an address-enable signal and the active-low read and write strobes.

The upper address byte is not given a port of its own. It is placed on the 8-bit data bus while the address strobe is high, and an external latch captures it when the strobe falls. The lower byte appears on a dedicated address output. Within a run, the strobe state is skipped whenever the next address has the same upper byte as the one the latch already holds. This makes block transfers one cycle shorter per transfer. A memory-to-memory transfer reads the source into a temporary register during one four-state pass, then writes that register to the destination during a second pass.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, hold_req, addr_en, addr_stb and tc are low and all four strobes (ior_n, iow_n, memr_n, memw_n) are high.
- R2: The idle machine raises hold_req only when dma_req is high, req_mask is low and the loaded count is nonzero. A masked request or a zero count leaves it idle.
- R3: While waiting for the bus, hold_req is high and addr_en stays low. In the cycle after hold_ack is sampled high, the first transfer state begins.
- R4: The first transfer state drives addr_en and addr_stb high, the upper address byte on db_out and the lower byte on addr_lo. addr_stb is high for exactly one cycle.
- R5: The first transfer of a run always produces an address strobe. A later transfer skips the strobe state when its upper address byte equals the last one strobed in the run, and strobes otherwise.
- R6: With cfg_mode 2'b00 (memory to I/O), memr_n is low in the third and fourth transfer states and iow_n is low in the fourth.
- R7: With cfg_mode 2'b01 (I/O to memory), ior_n is low in the third and fourth transfer states and memw_n is low in the fourth.
- R8: With cfg_mode bit 1 set (memory to memory), a read pass at the source address with memr_n low captures db_in at its fourth state. A write pass at the destination address then drives that byte on db_out while memw_n is low.
- R9: Each completed transfer advances the address (both addresses in memory-to-memory mode) by one and decrements the count. A run ends after exactly the loaded number of transfers.
- R10: abort high at the last state of a transfer ends the run after that transfer.
- R11: When a run ends, the next cycle has hold_req, addr_en and all strobes inactive and tc high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Loads configuration while idle |
| cfg_mode | input | 2 | Transfer kind: 00 mem to I/O, 01 I/O to mem, 1x mem to mem |
| cfg_src | input | ADDR_W | Start address (source in memory-to-memory mode) |
| cfg_dst | input | ADDR_W | Destination address for memory-to-memory mode |
| cfg_count | input | CNT_W | Number of transfers |
| dma_req | input | 1 | Transfer request |
| req_mask | input | 1 | Masks dma_req when high |
| hold_ack | input | 1 | Bus grant from the processor |
| abort | input | 1 | Ends the run at the next transfer boundary |
| db_in | input | 8 | Data bus input, read during memory-to-memory reads |
| hold_req | output | 1 | Bus request to the processor |
| addr_en | output | 1 | Address enable during transfer states |
| addr_stb | output | 1 | Strobe for the external upper-address latch |
| db_out | output | 8 | Upper address byte or memory-to-memory write data |
| addr_lo | output | 8 | Lower address byte |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| tc | output | 1 | One-cycle end-of-run pulse |

## Verification
Every output is decoded from registered state, so each result appears one clock after the edge that caused it. hold_req rises one cycle after an accepted request. The strobe state follows one cycle after hold_ack is seen. The write strobe falls three cycles after a strobe state, or two cycles after a skipped one. tc rises one cycle after the final write strobe. The bench drives inputs and samples outputs on the falling edge. A monitor compares each write cycle against an item queued by the driver, which holds the address, the expected number of strobes since the previous write, and the data. The driver checks the acquire and end phases cycle by cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } seq_state_e;
endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_ok,
    input  logic       cnt_nz,
    input  logic       cnt_last,
    input  logic       grant,
    input  logic       abort,
    input  logic       mm_mode,
    input  logic       hi_same,
    output seq_state_e state_q,
    output logic       wr_phase_q,
    output logic       tc_q,
    output logic       xfer_done
);
    typedef struct packed {
        seq_state_e state;
        logic       wr_phase;
        logic       tc;
    } ctrl_t;

    ctrl_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.tc    = 1'b0;
        xfer_done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                r_d.wr_phase = 1'b0;
                if (req_ok && cnt_nz) r_d.state = ST_ACQ;
            end
            ST_ACQ:  if (grant) r_d.state = ST_T1;
            ST_T1:   r_d.state = ST_T2;
            ST_T2:   r_d.state = ST_T3;
            ST_T3:   r_d.state = ST_T4;
            ST_T4: begin
                if (mm_mode && !r_q.wr_phase) begin
                    r_d.wr_phase = 1'b1;
                    r_d.state    = hi_same ? ST_T2 : ST_T1;
                end else begin
                    xfer_done    = 1'b1;
                    r_d.wr_phase = 1'b0;
                    if (cnt_last || abort) begin
                        r_d.state = ST_IDLE;
                        r_d.tc    = 1'b1;
                    end else begin
                        r_d.state = hi_same ? ST_T2 : ST_T1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.wr_phase <= 1'b0;
            r_q.tc       <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q    = r_q.state;
    assign wr_phase_q = r_q.wr_phase;
    assign tc_q       = r_q.tc;
endmodule

// File: rtl/dma_seq_path.sv
module dma_seq_path
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  seq_state_e        state,
    input  logic              wr_phase,
    input  logic              xfer_done,
    input  logic [7:0]        db_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        temp,
    output logic              mm_mode,
    output logic              io_to_mem,
    output logic              cnt_nz,
    output logic              cnt_last,
    output logic              hi_same
);
    localparam int HI_W = ADDR_W - LO_W;
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [CNT_W-1:0]  CNT_ONE  = 1;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        mode;
        logic [7:0]        temp;
        logic [HI_W-1:0]   last_hi;
        logic              last_valid;
    } path_t;

    path_t r_q, r_d;
    logic [ADDR_W-1:0] cand_addr;

    always_comb begin
        cur_addr  = (r_q.mode[1] && wr_phase) ? r_q.dst : r_q.src;
        cand_addr = (r_q.mode[1] && !wr_phase) ? r_q.dst : r_q.src + ADDR_ONE;
        hi_same   = r_q.last_valid && (cand_addr[ADDR_W-1:LO_W] == r_q.last_hi);

        r_d = r_q;
        if (state == ST_IDLE && cfg_load) begin
            r_d.src  = cfg_src;
            r_d.dst  = cfg_dst;
            r_d.cnt  = cfg_count;
            r_d.mode = cfg_mode;
        end
        if (state == ST_ACQ) r_d.last_valid = 1'b0;
        if (state == ST_T1) begin
            r_d.last_hi    = cur_addr[ADDR_W-1:LO_W];
            r_d.last_valid = 1'b1;
        end
        if (state == ST_T4 && r_q.mode[1] && !wr_phase) r_d.temp = db_in;
        if (xfer_done) begin
            r_d.src = r_q.src + ADDR_ONE;
            r_d.cnt = r_q.cnt - CNT_ONE;
            if (r_q.mode[1]) r_d.dst = r_q.dst + ADDR_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign temp      = r_q.temp;
    assign mm_mode   = r_q.mode[1];
    assign io_to_mem = r_q.mode[0];
    assign cnt_nz    = |r_q.cnt;
    assign cnt_last  = (r_q.cnt == CNT_ONE);
endmodule

// File: rtl/dma_seq_strobe.sv
module dma_seq_strobe
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LO_W   = 8
) (
    input  seq_state_e        state,
    input  logic              wr_phase,
    input  logic              mm_mode,
    input  logic              io_to_mem,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [7:0]        temp,
    output logic              hold_req,
    output logic              addr_en,
    output logic              addr_stb,
    output logic [7:0]        db_out,
    output logic [7:0]        addr_lo,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n
);
    logic active, rd_win, wr_win;

    always_comb begin
        active   = (state == ST_T1) || (state == ST_T2) || (state == ST_T3) || (state == ST_T4);
        rd_win   = (state == ST_T3) || (state == ST_T4);
        wr_win   = (state == ST_T4);
        hold_req = (state != ST_IDLE);
        addr_en  = active;
        addr_stb = (state == ST_T1);
        addr_lo  = active ? cur_addr[7:0] : 8'h00;
        if (state == ST_T1)                      db_out = 8'(cur_addr >> LO_W);
        else if (wr_win && mm_mode && wr_phase)  db_out = temp;
        else                                     db_out = 8'h00;

        ior_n  = 1'b1;
        iow_n  = 1'b1;
        memr_n = 1'b1;
        memw_n = 1'b1;
        if (mm_mode) begin
            memr_n = !(rd_win && !wr_phase);
            memw_n = !(wr_win && wr_phase);
        end else if (io_to_mem) begin
            ior_n  = !rd_win;
            memw_n = !wr_win;
        end else begin
            memr_n = !rd_win;
            iow_n  = !wr_win;
        end
    end
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_mode,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              dma_req,
    input  logic              req_mask,
    input  logic              hold_ack,
    input  logic              abort,
    input  logic [7:0]        db_in,
    output logic              hold_req,
    output logic              addr_en,
    output logic              addr_stb,
    output logic [7:0]        db_out,
    output logic [7:0]        addr_lo,
    output logic              ior_n,
    output logic              iow_n,
    output logic              memr_n,
    output logic              memw_n,
    output logic              tc
);
    localparam int LO_W = 8;

    seq_state_e        state;
    logic              wr_phase, xfer_done, mm_mode, io_to_mem;
    logic              cnt_nz, cnt_last, hi_same;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        temp;

    dma_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_ok     (dma_req && !req_mask),
        .cnt_nz     (cnt_nz),
        .cnt_last   (cnt_last),
        .grant      (hold_ack),
        .abort      (abort),
        .mm_mode    (mm_mode),
        .hi_same    (hi_same),
        .state_q    (state),
        .wr_phase_q (wr_phase),
        .tc_q       (tc),
        .xfer_done  (xfer_done)
    );

    dma_seq_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LO_W(LO_W)) u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_mode  (cfg_mode),
        .cfg_src   (cfg_src),
        .cfg_dst   (cfg_dst),
        .cfg_count (cfg_count),
        .state     (state),
        .wr_phase  (wr_phase),
        .xfer_done (xfer_done),
        .db_in     (db_in),
        .cur_addr  (cur_addr),
        .temp      (temp),
        .mm_mode   (mm_mode),
        .io_to_mem (io_to_mem),
        .cnt_nz    (cnt_nz),
        .cnt_last  (cnt_last),
        .hi_same   (hi_same)
    );

    dma_seq_strobe #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_strobe (
        .state     (state),
        .wr_phase  (wr_phase),
        .mm_mode   (mm_mode),
        .io_to_mem (io_to_mem),
        .cur_addr  (cur_addr),
        .temp      (temp),
        .hold_req  (hold_req),
        .addr_en   (addr_en),
        .addr_stb  (addr_stb),
        .db_out    (db_out),
        .addr_lo   (addr_lo),
        .ior_n     (ior_n),
        .iow_n     (iow_n),
        .memr_n    (memr_n),
        .memw_n    (memw_n)
    );
endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic hold_req,
    input logic hold_ack,
    input logic addr_en,
    input logic addr_stb,
    input logic ior_n,
    input logic iow_n,
    input logic memr_n,
    input logic memw_n,
    input logic tc
);
    p_stb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> !addr_stb);
    p_stb_with_aen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> addr_en);
    p_aen_needs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> hold_req);
    p_aen_after_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_en) |-> $past(hold_ack));
    p_iow_with_memr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !iow_n |-> !memr_n);
    p_ior_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ior_n |-> (memr_n && iow_n));
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |-> (iow_n || memw_n));
    p_tc_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    p_tc_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> (!hold_req && !addr_en && ior_n && iow_n && memr_n && memw_n));
endmodule

bind dma_cycle_seq dma_seq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .addr_en  (addr_en),
    .addr_stb (addr_stb),
    .ior_n    (ior_n),
    .iow_n    (iow_n),
    .memr_n   (memr_n),
    .memw_n   (memw_n),
    .tc       (tc)
);

// File: tb/dma_cycle_seq_test.sv
`timescale 1ns/1ps
module dma_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_count = '0;
    logic        dma_req = 1'b0, req_mask = 1'b0, hold_ack = 1'b0, abort = 1'b0;
    logic [7:0]  db_in, db_out, addr_lo;
    logic        hold_req, addr_en, addr_stb, ior_n, iow_n, memr_n, memw_n, tc;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] ext_latch = '0;
    int stb_cnt = 0;

    typedef struct {
        logic [15:0] addr;
        logic [1:0]  mode;
        logic [7:0]  data;
        int          strobes;
    } exp_t;
    exp_t expq[$];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign db_in = pat({ext_latch, addr_lo});

    dma_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_count(cfg_count),
        .dma_req(dma_req), .req_mask(req_mask), .hold_ack(hold_ack), .abort(abort),
        .db_in(db_in), .hold_req(hold_req), .addr_en(addr_en), .addr_stb(addr_stb),
        .db_out(db_out), .addr_lo(addr_lo), .ior_n(ior_n), .iow_n(iow_n),
        .memr_n(memr_n), .memw_n(memw_n), .tc(tc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: external latch model and per-write scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_stb) begin
                ext_latch = db_out;
                stb_cnt++;
            end
            if (!iow_n || !memw_n) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9 unexpected transfer", {ext_latch, addr_lo}, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({ext_latch, addr_lo} == e.addr, "R9 transfer address",
                          {ext_latch, addr_lo}, e.addr);
                    check(stb_cnt == e.strobes, "R5 strobes since last write", stb_cnt, e.strobes);
                    if (e.mode[1])
                        check(memr_n && ior_n && iow_n && !memw_n && db_out == e.data,
                              "R8 write pass strobes and data",
                              {ior_n, iow_n, memr_n, memw_n, db_out}, {4'b1110, e.data});
                    else if (e.mode[0])
                        check(!ior_n && !memw_n && memr_n && iow_n, "R7 strobes",
                              {ior_n, iow_n, memr_n, memw_n}, 4'b0110);
                    else
                        check(!memr_n && !iow_n && ior_n && memw_n, "R6 strobes",
                              {ior_n, iow_n, memr_n, memw_n}, 4'b1001);
                end
                stb_cnt = 0;
            end
        end
    end

    // Driver: queue expected items, then run one DMA sequence
    task automatic run_xfer(input logic [1:0] mode, input logic [15:0] src, input logic [15:0] dst,
                            input int cnt, input bit do_abort);
        int n;
        bit valid;
        logic [7:0] last;
        n = do_abort ? 1 : cnt;
        valid = 1'b0;
        last = '0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            logic [15:0] s, d;
            s = src + 16'(i);
            d = dst + 16'(i);
            e.mode = mode;
            e.strobes = (!valid || s[15:8] != last) ? 1 : 0;
            last = s[15:8];
            valid = 1'b1;
            if (mode[1]) begin
                if (d[15:8] != last) e.strobes++;
                last = d[15:8];
                e.addr = d;
                e.data = pat(s);
            end else begin
                e.addr = s;
                e.data = 8'h00;
            end
            expq.push_back(e);
        end
        stb_cnt = 0;
        cfg_mode = mode; cfg_src = src; cfg_dst = dst; cfg_count = 16'(cnt);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        abort = do_abort;
        dma_req = 1'b1;
        while (!hold_req) @(negedge clk);
        repeat (2) begin
            @(negedge clk);
            check(hold_req && !addr_en, "R3 waiting for grant", {hold_req, addr_en}, 2'b10);
        end
        hold_ack = 1'b1;
        @(negedge clk);
        check(addr_stb && addr_en && addr_lo == src[7:0] && db_out == (mode[1] ? src[15:8] : src[15:8]),
              "R4 first state after grant", {addr_stb, addr_en, db_out, addr_lo}, {2'b11, src});
        while (!tc) @(negedge clk);
        check(!hold_req && !addr_en && ior_n && iow_n && memr_n && memw_n, "R11 release at end",
              {hold_req, addr_en, ior_n, iow_n, memr_n, memw_n}, 6'b001111);
        check(expq.size() == 0, do_abort ? "R10 transfers left after abort" : "R9 transfers left",
              expq.size(), 0);
        dma_req = 1'b0; hold_ack = 1'b0; abort = 1'b0;
        @(negedge clk);
        check(!tc, "R11 tc one cycle", tc, 0);
        expq.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!hold_req && !addr_en && !addr_stb && !tc && ior_n && iow_n && memr_n && memw_n,
              "R1 reset state", {hold_req, addr_en, addr_stb, tc, ior_n, iow_n, memr_n, memw_n}, 8'h0F);

        // R2: zero count is ignored
        cfg_count = 16'd0; cfg_src = 16'h4000; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; dma_req = 1'b1;
        repeat (8) @(negedge clk);
        check(!hold_req, "R2 zero count stays idle", hold_req, 0);
        dma_req = 1'b0;

        // R2: masked request is ignored
        cfg_count = 16'd3; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; req_mask = 1'b1; dma_req = 1'b1;
        repeat (8) @(negedge clk);
        check(!hold_req, "R2 masked request stays idle", hold_req, 0);
        dma_req = 1'b0; req_mask = 1'b0;
        @(negedge clk);

        run_xfer(2'b00, 16'h1230, 16'h0000, 4, 1'b0);  // R6 R5 same page
        run_xfer(2'b01, 16'h12FE, 16'h0000, 4, 1'b0);  // R7 R5 page crossing
        run_xfer(2'b10, 16'h2040, 16'h5080, 3, 1'b0);  // R8 two strobes each
        run_xfer(2'b10, 16'h33F0, 16'h3300, 2, 1'b0);  // R8 R5 shared page
        run_xfer(2'b00, 16'h7000, 16'h0000, 5, 1'b1);  // R10 abort

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule